// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the programmable start address and transfer length of four DMA channels. Each value is 16 bits wide and is reached through a byte-wide host port, so a register is written or read as two bytes in a row. One shared byte pointer picks the byte. It is a two-state machine with states `PTR_LO` and `PTR_HI`. Any host access that hits a channel register takes the `LO_TO_HI` or `HI_TO_LO` transition. The `CLEAR` transition comes from reset or from the `ptr_clr` input, and it returns the pointer to `PTR_LO` from either state.

A write to the high byte starts the channel afresh. The working address is loaded from the programmed base, scaled by the width shift, and the progress count is zeroed. The transfer engine then raises `inc_valid` once per unit moved, and the progress count stops at the programmed size. Reads do not return the stored registers. The address register reads back the working address moved forward or backward by the progress count, and the count register reads back the units that remain. The parameter `WSHIFT` selects byte scaling (0) or word scaling (1).

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is `(host_off >> WSHIFT) & 15`. When bit 3 of the index is 0, bits [2:1] select channel 0 to 3, and bit 0 selects the address register (0) or the count register (1).
- R2: An access whose index has bit 3 set changes no register and does not move the byte pointer.
- R3: Each read or write that hits a channel register toggles the shared pointer. The pointer value before the toggle selects the low byte (`PTR_LO`) or the high byte (`PTR_HI`).
- R4: Reset and `ptr_clr` each return the pointer to `PTR_LO`. `ptr_clr` wins over an access in the same cycle, and that access still uses the old pointer value.
- R5: A low-byte write replaces bits [7:0] of the addressed base register. A high-byte write replaces bits [15:8].
- R6: A high-byte write to either register of a channel loads the working address with the new base address shifted left by `WSHIFT` and clears the progress count. This takes priority over an increment in the same cycle.
- R7: A count read yields `(base_count << WSHIFT) - progress`.
- R8: An address read yields `working_address + progress` when `chan_dec` of that channel is 0, and `working_address - progress` when it is 1.
- R9: The returned byte is the computed value (kept to 17+`WSHIFT` bits) shifted right by `WSHIFT + 8*pointer` and masked to 8 bits. It is valid in the same cycle as `host_rd`.
- R10: Each `inc_valid` pulse adds 1 to the progress count of channel `inc_chan`, up to the limit `(base_count + 1) << WSHIFT`, and the count holds at that limit.
- R11: After reset every base register, working address and progress count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_off | input | OFF_W | Host port offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| ptr_clr | input | 1 | Return the byte pointer to the low byte |
| chan_dec | input | 4 | Per-channel address-decrement direction |
| inc_valid | input | 1 | Progress increment from the transfer engine |
| inc_chan | input | 2 | Channel that receives the increment |

## Verification
The assertions assume the host never raises `host_wr` and `host_rd` in the same cycle. They also assume that `inc_valid` is sampled only with a defined `inc_chan`. The stimulus draws one operation per cycle from write, read, increment and clear, so the two strobes are never high together. It also drives the bare register index, scaled by `WSHIFT`, to two instances (byte and word scaling) at once, so both share one pointer history. Directed steps cover saturation, the pointer clear and the ignored indices.

// File: rtl/dma_regs_pkg.sv
`timescale 1ns/1ps
package dma_regs_pkg;
    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_e;
endpackage

// File: rtl/dma_byte_ptr.sv
`timescale 1ns/1ps
module dma_byte_ptr
    import dma_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access,
    input  logic       clr,
    output ptr_state_e state
);
    ptr_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PTR_LO;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            PTR_LO: if (access) state_nxt = PTR_HI;   // LO_TO_HI
            PTR_HI: if (access) state_nxt = PTR_LO;   // HI_TO_LO
            default: state_nxt = PTR_LO;
        endcase
        if (clr) state_nxt = PTR_LO;                  // CLEAR
    end
endmodule

// File: rtl/dma_chan_slot.sv
`timescale 1ns/1ps
module dma_chan_slot #(
    parameter int WSHIFT = 0,
    parameter int VW     = 17 + WSHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          sel_cnt,
    input  logic          hi_byte,
    input  logic [7:0]    wdata,
    input  logic          inc,
    output logic [15:0]   base_addr,
    output logic [15:0]   base_cnt,
    output logic [VW-1:0] cur_addr,
    output logic [VW-1:0] prog
);
    logic [15:0]   addr_new;
    logic [VW-1:0] limit;

    assign addr_new = sel_cnt ? base_addr : {wdata, base_addr[7:0]};
    assign limit    = VW'((VW'(base_cnt) + VW'(1)) << WSHIFT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            prog      <= '0;
        end else begin
            if (wr_en && !sel_cnt) begin
                if (hi_byte) base_addr[15:8] <= wdata;
                else         base_addr[7:0]  <= wdata;
            end
            if (wr_en && sel_cnt) begin
                if (hi_byte) base_cnt[15:8] <= wdata;
                else         base_cnt[7:0]  <= wdata;
            end
            if (wr_en && hi_byte) begin
                cur_addr <= VW'(VW'(addr_new) << WSHIFT);
                prog     <= '0;
            end else if (inc && (prog < limit)) begin
                prog <= prog + VW'(1);
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int WSHIFT = 0,
    parameter int OFF_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] host_off,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             ptr_clr,
    input  logic [3:0]       chan_dec,
    input  logic             inc_valid,
    input  logic [1:0]       inc_chan
);
    localparam int IDX_W  = 4;
    localparam int NUM_CH = 1 << (IDX_W - 2);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int VW     = 17 + WSHIFT;

    logic [IDX_W-1:0] reg_idx;
    logic             chan_hit;
    logic [CH_W-1:0]  ch_sel;
    logic             is_cnt;
    logic             access;
    ptr_state_e       ptr_state;
    logic             ptr_hi;

    logic [NUM_CH-1:0][15:0]   base_addr_all;
    logic [NUM_CH-1:0][15:0]   base_cnt_all;
    logic [NUM_CH-1:0][VW-1:0] cur_addr_all;
    logic [NUM_CH-1:0][VW-1:0] prog_all;

    assign reg_idx  = IDX_W'(host_off >> WSHIFT);
    assign chan_hit = !reg_idx[IDX_W-1];
    assign ch_sel   = reg_idx[CH_W:1];
    assign is_cnt   = reg_idx[0];
    assign access   = (host_wr || host_rd) && chan_hit;
    assign ptr_hi   = (ptr_state == PTR_HI);

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (access),
        .clr    (ptr_clr),
        .state  (ptr_state)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_chan_slot #(.WSHIFT(WSHIFT), .VW(VW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (host_wr && chan_hit && (ch_sel == CH_W'(g))),
            .sel_cnt   (is_cnt),
            .hi_byte   (ptr_hi),
            .wdata     (host_wdata),
            .inc       (inc_valid && (inc_chan == CH_W'(g))),
            .base_addr (base_addr_all[g]),
            .base_cnt  (base_cnt_all[g]),
            .cur_addr  (cur_addr_all[g]),
            .prog      (prog_all[g])
        );
    end

    logic [VW-1:0] live_val;
    logic [VW-1:0] live_shifted;

    always_comb begin
        if (is_cnt)
            live_val = VW'(VW'(base_cnt_all[ch_sel]) << WSHIFT) - prog_all[ch_sel];
        else if (chan_dec[ch_sel])
            live_val = cur_addr_all[ch_sel] - prog_all[ch_sel];
        else
            live_val = cur_addr_all[ch_sel] + prog_all[ch_sel];
        live_shifted = live_val >> (WSHIFT + (ptr_hi ? 8 : 0));
        host_rdata   = (host_rd && chan_hit) ? live_shifted[7:0] : 8'h00;
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
`timescale 1ns/1ps
module dma_chan_regs_chk #(
    parameter int WSHIFT = 0,
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2,
    parameter int VW     = 17
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      host_wr,
    input logic                      host_rd,
    input logic                      ptr_clr,
    input logic                      access,
    input logic                      ptr_hi,
    input logic                      chan_hit,
    input logic [CH_W-1:0]           ch_sel,
    input logic                      is_cnt,
    input logic [7:0]                host_wdata,
    input logic [NUM_CH-1:0][15:0]   base_addr_all,
    input logic [NUM_CH-1:0][VW-1:0] prog_all
);
    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !ptr_hi);                                                  // R4
    AST_PTR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ptr_clr) |=> (ptr_hi != $past(ptr_hi)));                   // R3
    AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !host_rd && !ptr_clr) |=> $stable(ptr_hi));               // R3
    AST_CTRL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && !chan_hit && !ptr_clr) |=> $stable(ptr_hi));  // R2

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && chan_hit && ch_sel == CH_W'(g) && ptr_hi)
            |=> (prog_all[g] == '0));                                          // R6
        AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_all[g] != $past(prog_all[g]))
            |-> (prog_all[g] == '0 || prog_all[g] == $past(prog_all[g]) + VW'(1))); // R10
        AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && chan_hit && ch_sel == CH_W'(g) && !ptr_hi && !is_cnt)
            |=> (base_addr_all[g][7:0] == $past(host_wdata)));                 // R5
    end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
    .WSHIFT(WSHIFT), .NUM_CH(NUM_CH), .CH_W(CH_W), .VW(VW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .ptr_clr       (ptr_clr),
    .access        (access),
    .ptr_hi        (ptr_hi),
    .chan_hit      (chan_hit),
    .ch_sel        (ch_sel),
    .is_cnt        (is_cnt),
    .host_wdata    (host_wdata),
    .base_addr_all (base_addr_all),
    .prog_all      (prog_all)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] off0 = '0, off1 = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0, ptr_clr = 1'b0, inc_valid = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [3:0] chan_dec = '0;
    logic [1:0] inc_chan = '0;
    logic [7:0] rd0, rd1;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    dma_chan_regs #(.WSHIFT(0)) dut (
        .clk(clk), .rst_n(rst_n), .host_off(off0), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(rd0), .ptr_clr(ptr_clr), .chan_dec(chan_dec),
        .inc_valid(inc_valid), .inc_chan(inc_chan));

    dma_chan_regs #(.WSHIFT(1)) dut_w (
        .clk(clk), .rst_n(rst_n), .host_off(off1), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(rd1), .ptr_clr(ptr_clr), .chan_dec(chan_dec),
        .inc_valid(inc_valid), .inc_chan(inc_chan));

    // reference model, index [k] = WSHIFT
    longint m_ba[2][4], m_bc[2][4], m_cur[2][4], m_prog[2][4];
    bit     m_ptr[2];

    function automatic int exp_byte(int k, int ip, bit dec);
        longint v;
        int c = ip >> 1;
        if (ip & 1)   v = (m_bc[k][c] << k) - m_prog[k][c];
        else if (dec) v = m_cur[k][c] - m_prog[k][c];
        else          v = m_cur[k][c] + m_prog[k][c];
        v = v & ((longint'(1) << (17 + k)) - 1);
        return int'((v >> (k + 8 * m_ptr[k])) & 255);
    endfunction

    task automatic chk(string tag, int k, int act, int expv);
        checks++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s inst%0d actual=%02h expected=%02h", tag, k, act, expv);
        end
    endtask

    task automatic op(bit wr, bit rd, int ip, int d, bit clr, bit inc, int ich, string tag);
        @(negedge clk);
        host_wr = wr; host_rd = rd; off0 = 8'(ip); off1 = 8'(ip << 1);
        host_wdata = 8'(d); ptr_clr = clr; inc_valid = inc; inc_chan = 2'(ich);
        #2;
        if (rd && ip < 8) begin
            chk(tag, 0, int'(rd0), exp_byte(0, ip, chan_dec[ip >> 1]));
            chk(tag, 1, int'(rd1), exp_byte(1, ip, chan_dec[ip >> 1]));
        end
        for (int k = 0; k < 2; k++) begin
            int c = ip >> 1;
            bit hit = (ip < 8);
            if (inc && m_prog[k][ich] < ((m_bc[k][ich] + 1) << k)) m_prog[k][ich]++;
            if (wr && hit) begin
                if (ip & 1) m_bc[k][c] = m_ptr[k] ? ((m_bc[k][c] & 255) | (d << 8)) : ((m_bc[k][c] & 16'hff00) | d);
                else        m_ba[k][c] = m_ptr[k] ? ((m_ba[k][c] & 255) | (d << 8)) : ((m_ba[k][c] & 16'hff00) | d);
                if (m_ptr[k]) begin
                    m_cur[k][c] = m_ba[k][c] << k;
                    m_prog[k][c] = 0;
                end
            end
            if (clr) m_ptr[k] = 0;
            else if ((wr || rd) && hit) m_ptr[k] = !m_ptr[k];
        end
        @(posedge clk);
        #1;
        host_wr = 0; host_rd = 0; ptr_clr = 0; inc_valid = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1357;
        void'($urandom(seed));
        for (int k = 0; k < 2; k++) begin
            m_ptr[k] = 0;
            for (int c = 0; c < 4; c++) begin
                m_ba[k][c] = 0; m_bc[k][c] = 0; m_cur[k][c] = 0; m_prog[k][c] = 0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state, low byte of every register
        for (int ip = 0; ip < 8; ip++) begin
            op(0, 1, ip, 0, 1, 0, 0, "R11 reset");
        end

        // R1 R5 R6: distinct channels, addresses read back
        for (int c = 0; c < 4; c++) begin
            op(1, 0, 2 * c, 8'h10 + c, 0, 0, 0, "R5");
            op(1, 0, 2 * c, 8'hA0 + c, 0, 0, 0, "R6");
        end
        for (int c = 0; c < 4; c++) begin
            op(0, 1, 2 * c, 0, 0, 0, 0, "R1 R9 lo");
            op(0, 1, 2 * c, 0, 0, 0, 0, "R1 R9 hi");
        end

        // R10 R7: saturation on channel 2 with count 2
        op(1, 0, 5, 2, 0, 0, 0, "R5");
        op(1, 0, 5, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 10; i++) op(0, 0, 0, 0, 0, 1, 2, "R10");
        op(0, 1, 5, 0, 0, 0, 0, "R10 R7 lo");
        op(0, 1, 5, 0, 0, 0, 0, "R10 R7 hi");

        // R8: both directions on channel 2
        chan_dec = 4'b0100;
        op(0, 1, 4, 0, 0, 0, 0, "R8 dec lo");
        op(0, 1, 4, 0, 0, 0, 0, "R8 dec hi");
        chan_dec = 4'b0000;
        op(0, 1, 4, 0, 0, 0, 0, "R8 inc lo");
        op(0, 1, 4, 0, 0, 0, 0, "R8 inc hi");

        // R2: control indices leave pointer and registers alone
        op(1, 0, 0, 8'h55, 0, 0, 0, "R3");
        op(1, 0, 9, 8'hEE, 0, 0, 0, "R2");
        op(0, 1, 12, 0, 0, 0, 0, "R2");
        op(1, 0, 0, 8'h66, 0, 0, 0, "R2 R6");
        op(0, 1, 0, 0, 0, 0, 0, "R2 lo");
        op(0, 1, 0, 0, 0, 0, 0, "R2 hi");

        // R4: clear after one byte, and clear beating a same-cycle access
        op(0, 1, 6, 0, 0, 0, 0, "R3");
        op(0, 0, 0, 0, 1, 0, 0, "R4");
        op(0, 1, 6, 0, 0, 0, 0, "R4 lo");
        op(0, 1, 6, 0, 1, 0, 0, "R4 hi same cycle");
        op(0, 1, 6, 0, 0, 0, 0, "R4 after clr");

        // R6: reload beats same-cycle increment
        op(1, 0, 3, 8'h01, 0, 0, 0, "R5");
        op(1, 0, 3, 8'h00, 0, 1, 1, "R6 vs inc");
        op(0, 1, 3, 0, 0, 0, 0, "R6 R7 lo");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            int ip = int'($urandom % 16);
            chan_dec = 4'($urandom);
            if (r < 35)      op(1, 0, ip, int'($urandom % 256), 0, 0, 0, "R5 R6 rand");
            else if (r < 70) op(0, 1, ip, 0, 0, 0, 0, "R7 R8 R9 rand");
            else if (r < 95) op(0, 0, 0, 0, 0, 1, int'($urandom % 4), "R10 rand");
            else             op(0, 0, 0, 0, 1, 0, 0, "R4 rand");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule